// File: doc/BRIEF.md
# Bitplane Fetch Window Sequencer

This block decides, bus cycle by bus cycle, when the display engine may read bitplane data from memory during a scanline. It watches the horizontal bus-cycle count of the line and compares it against two programmable positions, a fetch start and a fetch stop. Fetching is organised in fixed-length blocks: eight bus cycles per block at low resolution and four at high resolution. Each slot in a block is either given to one bitplane or left idle.

A match on the start position opens the window. The grants come out a fixed lead time later. Blocks follow each other back to back until a block begins at or beyond the stop position. That block is the last one, and it always runs to its end. A short band of bus cycles near the end of the line never receives a grant. After every completed block, a one-cycle strobe marks the moment when that block's data may be shown.

The host writes the start and stop positions through a simple write port. The resolution mode and the plane count are static inputs that the block samples at the start of each block.

Top module: `bitplane_fetch_seq`

## Requirements
- R1: After reset, `fetch_o` and `ready_o` are low, the start position is 0x38 and the stop position is 0xD0.
- R2: A write with `cfg_sel_i`=0 loads the start position and one with `cfg_sel_i`=1 loads the stop position. The new value is used for every comparison made at a later count, including comparisons later in the same line.
- R3: When the window is idle and the sampled count equals the start position S, a block begins at position S. The slot at position p is presented while `hcount_i` equals p+4.
- R4: With `hires_i`=0 a block spans 8 positions, and with `hires_i`=1 it spans 4. A block that is not the last is followed at once by the next.
- R5: Slot i of a block (i counted from 0) grants plane i, shown on `fetch_plane_o`, when i is below the effective plane count. The effective count is `planes_i` capped at 6 for low resolution and at 4 for high resolution. Every other slot is idle.
- R6: A block that begins at a position greater than or equal to the stop position is the last block, and it runs its full length. Lowering the stop value while a block is running does not shorten that block.
- R7: `fetch_o` is never high while `hcount_i` is in the range 0xDC to 0xDF. A slot that would fall there is dropped and is not moved to another cycle.
- R8: `ready_o` pulses high for one cycle, 5 cycles after the cycle that carried the last slot position of each block. It pulses even when no plane was granted in that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcount_i | input | HCNT_W | Horizontal bus-cycle count; advances by one each clock and wraps at LINE_LEN |
| cfg_wr_i | input | 1 | Write strobe for a position register |
| cfg_sel_i | input | 1 | Register select: 0 start, 1 stop |
| cfg_data_i | input | HCNT_W | Value to write |
| hires_i | input | 1 | 0 low resolution, 1 high resolution |
| planes_i | input | PLANE_W | Number of planes to fetch |
| fetch_o | output | 1 | Fetch grant for the current bus cycle |
| fetch_plane_o | output | PLANE_W | Plane served by the grant |
| ready_o | output | 1 | Strobe: the data of a completed block may be displayed |

## Verification
The bench builds the block with LINE_LEN set to 240 and keeps every other parameter at its default. The longer line lets a low-resolution block that starts at 0xD8 finish, and lets its ready strobe fire, inside the same line. This brings the masked band 0xDC–0xDF within reach for both block lengths, without wrap-around blurring the arithmetic model. Every plane count from 0 to 7 is swept in both modes over several windows: the nominal one, a wide one, a misaligned stop, a single block, and a stop placed before the start. Two directed lines rewrite the stop position in the middle of a line.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
    typedef enum logic {
        RES_LO = 1'b0,
        RES_HI = 1'b1
    } res_e;

    typedef enum logic {
        SEL_START = 1'b0,
        SEL_STOP  = 1'b1
    } pos_sel_e;
endpackage

// File: rtl/bpf_window_regs.sv
module bpf_window_regs #(
    parameter int HCNT_W    = 8,
    parameter int RST_START = 'h38,
    parameter int RST_STOP  = 'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [HCNT_W-1:0] data_i,
    output logic [HCNT_W-1:0] start_o,
    output logic [HCNT_W-1:0] stop_o
);
    import bpf_pkg::*;

    typedef struct packed {
        logic [HCNT_W-1:0] start;
        logic [HCNT_W-1:0] stop;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (wr_i) begin
            if (pos_sel_e'(sel_i) == SEL_START) win_d.start = data_i;
            else                                win_d.stop  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q.start <= HCNT_W'(RST_START);
            win_q.stop  <= HCNT_W'(RST_STOP);
        end else begin
            win_q <= win_d;
        end
    end

    assign start_o = win_q.start;
    assign stop_o  = win_q.stop;
endmodule

// File: rtl/bpf_block_seq.sv
module bpf_block_seq #(
    parameter int HCNT_W        = 8,
    parameter int PLANE_W       = 3,
    parameter int LINE_LEN      = 227,
    parameter int BLK_LO        = 8,
    parameter int BLK_HI        = 4,
    parameter int MAX_PLANES_LO = 6,
    parameter int MAX_PLANES_HI = 4,
    parameter int LEAD          = 4,
    parameter int FORBID_FIRST  = 'hDC,
    parameter int FORBID_LAST   = 'hDF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HCNT_W-1:0]  hcount_i,
    input  logic [HCNT_W-1:0]  start_i,
    input  logic [HCNT_W-1:0]  stop_i,
    input  logic               hires_i,
    input  logic [PLANE_W-1:0] planes_i,
    output logic               slot_vld_o,
    output logic [PLANE_W-1:0] slot_plane_o,
    output logic               blk_done_o
);
    import bpf_pkg::*;

    localparam int CNT_W = (BLK_LO > 1) ? $clog2(BLK_LO) : 1;
    localparam int POS_W = HCNT_W + 1;
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(BLK_LO - 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(BLK_HI - 1);

    typedef struct packed {
        logic               active;
        logic [CNT_W-1:0]   idx;
        logic               hires;
        logic [PLANE_W-1:0] eff;
        logic               final_blk;
    } seq_t;

    seq_t seq_d, seq_q;

    logic               begin_c;
    logic               in_blk_c;
    logic               mode_c;
    logic [PLANE_W-1:0] eff_c;
    logic               final_c;
    logic [CNT_W-1:0]   idx_c;
    logic               last_c;
    logic [POS_W-1:0]   pos_c;
    logic               forbid_c;

    function automatic logic [PLANE_W-1:0] cap_planes(input logic hi, input logic [PLANE_W-1:0] n);
        int lim;
        lim = (res_e'(hi) == RES_HI) ? MAX_PLANES_HI : MAX_PLANES_LO;
        return (int'(n) > lim) ? PLANE_W'(lim) : n;
    endfunction

    always_comb begin
        // bus position at which this slot will be presented
        pos_c = {1'b0, hcount_i} + POS_W'(LEAD);
        if (pos_c >= POS_W'(LINE_LEN)) pos_c = pos_c - POS_W'(LINE_LEN);
        forbid_c = (pos_c >= POS_W'(FORBID_FIRST)) && (pos_c <= POS_W'(FORBID_LAST));

        begin_c  = (!seq_q.active && (hcount_i == start_i)) ||
                   (seq_q.active && (seq_q.idx == '0));
        in_blk_c = begin_c || seq_q.active;
        mode_c   = begin_c ? hires_i : seq_q.hires;
        eff_c    = begin_c ? cap_planes(hires_i, planes_i) : seq_q.eff;
        final_c  = begin_c ? (hcount_i >= stop_i) : seq_q.final_blk;
        idx_c    = begin_c ? '0 : seq_q.idx;
        last_c   = (res_e'(mode_c) == RES_HI) ? (idx_c == HI_LAST) : (idx_c == LO_LAST);

        slot_vld_o   = in_blk_c && (int'(idx_c) < int'(eff_c)) && !forbid_c;
        slot_plane_o = PLANE_W'(idx_c);
        blk_done_o   = in_blk_c && last_c;

        seq_d = seq_q;
        if (in_blk_c) begin
            seq_d.hires     = mode_c;
            seq_d.eff       = eff_c;
            seq_d.final_blk = final_c;
            if (last_c) begin
                seq_d.active = !final_c;
                seq_d.idx    = '0;
            end else begin
                seq_d.active = 1'b1;
                seq_d.idx    = idx_c + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/bpf_delay_line.sv
module bpf_delay_line #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } dl_t;

    dl_t dl_d, dl_q;

    always_comb begin
        dl_d        = dl_q;
        dl_d.stg[0] = din_i;
        for (int i = 1; i < DEPTH; i++) dl_d.stg[i] = dl_q.stg[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= dl_d;
    end

    assign dout_o = dl_q.stg[DEPTH-1];
endmodule

// File: rtl/bitplane_fetch_seq.sv
module bitplane_fetch_seq #(
    parameter int HCNT_W        = 8,
    parameter int PLANE_W       = 3,
    parameter int LINE_LEN      = 227,
    parameter int BLK_LO        = 8,
    parameter int BLK_HI        = 4,
    parameter int MAX_PLANES_LO = 6,
    parameter int MAX_PLANES_HI = 4,
    parameter int LEAD          = 4,
    parameter int DISP_LAT      = 5,
    parameter int FORBID_FIRST  = 'hDC,
    parameter int FORBID_LAST   = 'hDF,
    parameter int RST_START     = 'h38,
    parameter int RST_STOP      = 'hD0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HCNT_W-1:0]  hcount_i,
    input  logic               cfg_wr_i,
    input  logic               cfg_sel_i,
    input  logic [HCNT_W-1:0]  cfg_data_i,
    input  logic               hires_i,
    input  logic [PLANE_W-1:0] planes_i,
    output logic               fetch_o,
    output logic [PLANE_W-1:0] fetch_plane_o,
    output logic               ready_o
);
    localparam int GRANT_W   = 1 + PLANE_W;
    localparam int RDY_DEPTH = LEAD + DISP_LAT;

    logic [HCNT_W-1:0]  start_w, stop_w;
    logic               slot_vld_w, blk_done_w;
    logic [PLANE_W-1:0] slot_plane_w;
    logic [GRANT_W-1:0] grant_w;

    bpf_window_regs #(
        .HCNT_W(HCNT_W), .RST_START(RST_START), .RST_STOP(RST_STOP)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .sel_i(cfg_sel_i),
        .data_i(cfg_data_i), .start_o(start_w), .stop_o(stop_w)
    );

    bpf_block_seq #(
        .HCNT_W(HCNT_W), .PLANE_W(PLANE_W), .LINE_LEN(LINE_LEN),
        .BLK_LO(BLK_LO), .BLK_HI(BLK_HI),
        .MAX_PLANES_LO(MAX_PLANES_LO), .MAX_PLANES_HI(MAX_PLANES_HI),
        .LEAD(LEAD), .FORBID_FIRST(FORBID_FIRST), .FORBID_LAST(FORBID_LAST)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .hcount_i(hcount_i),
        .start_i(start_w), .stop_i(stop_w),
        .hires_i(hires_i), .planes_i(planes_i),
        .slot_vld_o(slot_vld_w), .slot_plane_o(slot_plane_w),
        .blk_done_o(blk_done_w)
    );

    bpf_delay_line #(.W(GRANT_W), .DEPTH(LEAD)) grant_dl_i (
        .clk(clk), .rst_n(rst_n),
        .din_i({slot_vld_w, slot_plane_w}), .dout_o(grant_w)
    );

    bpf_delay_line #(.W(1), .DEPTH(RDY_DEPTH)) ready_dl_i (
        .clk(clk), .rst_n(rst_n), .din_i(blk_done_w), .dout_o(ready_o)
    );

    assign fetch_o       = grant_w[GRANT_W-1];
    assign fetch_plane_o = grant_w[PLANE_W-1:0];
endmodule

// File: rtl/bitplane_fetch_seq_chk.sv
module bitplane_fetch_seq_chk #(
    parameter int HCNT_W        = 8,
    parameter int PLANE_W       = 3,
    parameter int MAX_PLANES_LO = 6,
    parameter int FORBID_FIRST  = 'hDC,
    parameter int FORBID_LAST   = 'hDF
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HCNT_W-1:0]  hcount_i,
    input logic               fetch_o,
    input logic [PLANE_W-1:0] fetch_plane_o,
    input logic               ready_o
);
    // R1: outputs quiet in the cycle after any reset cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!fetch_o && !ready_o));

    // R7: no grant inside the masked band
    p_no_forbidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> !((int'(hcount_i) >= FORBID_FIRST) && (int'(hcount_i) <= FORBID_LAST)));

    // R5: a granted plane lies below the largest plane count
    p_plane_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> (int'(fetch_plane_o) < MAX_PLANES_LO));

    // R5: back-to-back grants step through the planes in order
    p_plane_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && $past(fetch_o) && (fetch_plane_o != '0))
            |-> (fetch_plane_o == PLANE_W'($past(fetch_plane_o) + 1'b1)));

    // R8: the ready strobe lasts one cycle
    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);
endmodule

bind bitplane_fetch_seq bitplane_fetch_seq_chk #(
    .HCNT_W(HCNT_W), .PLANE_W(PLANE_W), .MAX_PLANES_LO(MAX_PLANES_LO),
    .FORBID_FIRST(FORBID_FIRST), .FORBID_LAST(FORBID_LAST)
) chk_i (
    .clk(clk), .rst_n(rst_n), .hcount_i(hcount_i),
    .fetch_o(fetch_o), .fetch_plane_o(fetch_plane_o), .ready_o(ready_o)
);

// File: tb/bitplane_fetch_seq_tb_top.sv
module bitplane_fetch_seq_tb_top;
    localparam int LINE = 240;
    localparam int LEAD = 4;
    localparam int DL   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hcount = '0;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       hires = 1'b0;
    logic [2:0] planes = '0;
    logic       fetch;
    logic [2:0] fetch_plane;
    logic       ready;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bitplane_fetch_seq #(.LINE_LEN(LINE)) dut_i (
        .clk(clk), .rst_n(rst_n), .hcount_i(hcount),
        .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
        .hires_i(hires), .planes_i(planes),
        .fetch_o(fetch), .fetch_plane_o(fetch_plane), .ready_o(ready)
    );

    // Expected outputs while hcount shows h, for start S, last block index kl
    task automatic model(input int h, input int s, input int kl, input int blen,
                         input int neff, output bit g, output int pl, output bit r);
        int x, y;
        g = 0; pl = 0; r = 0;
        x = h - LEAD;
        if (x >= s && ((x - s) / blen) <= kl && ((x - s) % blen) < neff &&
            !(h >= 'hDC && h <= 'hDF)) begin
            g = 1; pl = (x - s) % blen;
        end
        y = h - (blen - 1) - LEAD - DL;
        if (y >= s && ((y - s) % blen) == 0 && ((y - s) / blen) <= kl) r = 1;
    endtask

    task automatic run_line(input int s, input int p, input int kl, input bit hi,
                            input int np, input bit do_cfg, input int wr_h,
                            input int wr_val, input string tag);
        int blen, neff, pl;
        bit g, r;
        blen = hi ? 4 : 8;
        neff = (np > (hi ? 4 : 6)) ? (hi ? 4 : 6) : np;
        for (int h = 0; h < LINE; h++) begin
            @(posedge clk); #1;
            hcount = 8'(h);
            hires  = hi;
            planes = 3'(np);
            cfg_wr = 1'b0;
            if (do_cfg && h == 1) begin cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = 8'(s); end
            if (do_cfg && h == 2) begin cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_data = 8'(p); end
            if (h == wr_h)        begin cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_data = 8'(wr_val); end
            @(negedge clk);
            model(h, s, kl, blen, neff, g, pl, r);
            checks++;
            if (fetch !== g || (g && int'(fetch_plane) != pl)) begin
                failures++;
                $display("FAIL %s %s grant h=%0h got fetch=%0b plane=%0d exp fetch=%0b plane=%0d",
                         tag, (h >= 'hDC && h <= 'hDF) ? "R7" : "R5", h, fetch, fetch_plane, g, pl);
            end
            checks++;
            if (ready !== r) begin
                failures++;
                $display("FAIL %s R8 ready h=%0h got %0b exp %0b", tag, h, ready, r);
            end
        end
    endtask

    function automatic int last_idx(input int s, input int p, input int blen);
        if (p <= s) return 0;
        return (p - s + blen - 1) / blen;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int wins[5][2];
        wins[0] = '{'h38, 'hD0};
        wins[1] = '{'h20, 'hD8};
        wins[2] = '{'h40, 'h41};
        wins[3] = '{'h60, 'h60};
        wins[4] = '{'h70, 'h50};

        repeat (3) @(negedge clk);
        checks++;
        if (fetch !== 1'b0 || ready !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset outputs got fetch=%0b ready=%0b exp 0 0", fetch, ready);
        end
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: default positions 0x38..0xD0, no writes
        run_line('h38, 'hD0, last_idx('h38, 'hD0, 8), 1'b0, 6, 1'b0, -1, 0, "R1 R3 R4");

        // R3 R4 R5 R6 R7: sweep of windows, modes and plane counts
        for (int w = 0; w < 5; w++)
            for (int m = 0; m < 2; m++)
                for (int n = 0; n < 8; n++)
                    run_line(wins[w][0], wins[w][1],
                             last_idx(wins[w][0], wins[w][1], m ? 4 : 8),
                             m[0], n, 1'b1, -1, 0, "R3 R4 R5 R6");

        // R2: stop lowered mid-line to 0x70, last block begins at 0x70
        run_line('h38, 'hD0, 7, 1'b0, 6, 1'b1, 'h60, 'h70, "R2");
        // R6: stop drops to 0x40 inside block 0x40; that block and 0x48 complete
        run_line('h38, 'hD0, 2, 1'b0, 5, 1'b1, 'h45, 'h40, "R6");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule